// File: doc/BRIEF.md
# Power-Management Capability State Controller

This block holds the power-management capability structure of a bus function and the function's device power state. The host reaches it through a configuration access channel. A read returns one 32-bit configuration dword. A write carries data and byte enables. The capability pointer dword names the structure's fixed base, offset 0x40. The dword at the base holds the identifier, the link to the next capability and the capability word. The dword after it holds the control/status field, the bridge extension byte and the data byte.

The host moves the function between D0 (normal), D1 (bus idle), D2 (clock stop) and D3 (power down) by writing the state field. The local processor needs to know when this happens. A legal move to a deeper state sets a sticky power-down interrupt. A legal return to D0 sets a sticky restore interrupt. Each flag stays set until the local side pulses its clear input. The current state is also driven on a plain output for the local power logic.

The access channel uses valid/ready. A request moves when `req_valid` and `req_ready` are both high. Only reads produce a response. The response is held on `rsp_valid`/`rsp_rdata` until `rsp_ready` takes it. While a response waits, no new request of either kind is accepted.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset the state is D0 (code 00), both interrupt flags are low, no response is pending and `req_ready` is high.
- R2: A read of the capability pointer dword (byte address 0x34) returns 0x00000040.
- R3: A read of the dword at 0x40 returns 0x06020001. Bits 7:0 hold ID 0x01 and bits 15:8 hold next pointer 0x00. Bits 31:16 hold capability word 0x0602: version 010 in bits 2:0, D1 support in bit 9 and D2 support in bit 10.
- R4: A read of the dword at 0x44 returns the state code in bits 1:0 (00 D0, 01 D1, 10 D2, 11 D3). All its other bits read 0, including bridge extension bits 23:16 and data bits 31:24. Other offsets read 0. Address bits 1:0 are ignored.
- R5: The state changes only on an accepted write to dword 0x44 with byte enable 0 set, taking its value from data bits 1:0. The new state shows on `pwr_state` after the accepting edge. Writes with byte enable 0 clear, or to other offsets, change nothing.
- R6: From any state a write of a deeper state or of D0 is taken. A write of a shallower state other than D0 is ignored, and so is a write of a state the capability word marks unsupported.
- R7: A taken write to a deeper state sets `pd_irq`. A taken write of D0 from a non-D0 state sets `rs_irq`. A write of the current state sets neither flag. Both flags rise at the same edge as the state.
- R8: Each flag stays high until a cycle with its clear input high. When a set and a clear fall in the same cycle, the set wins.
- R9: Every accepted read yields exactly one response, in request order. A response is held stable until taken. `req_ready` is low while a response is pending and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Configuration request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Byte address of the configuration dword |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response accepted by the host side |
| rsp_rdata | output | 32 | Read response data |
| pwr_state | output | 2 | Current power state code |
| pd_irq | output | 1 | Sticky power-down interrupt |
| pd_clr | input | 1 | Clear for `pd_irq` |
| rs_irq | output | 1 | Sticky restore interrupt |
| rs_clr | input | 1 | Clear for `rs_irq` |

## Verification
The assertions check several properties on every cycle:
- a waiting response stays stable and every accepted read produces a response;
- the state never moves to a shallower non-D0 state and moves only after an accepted write;
- each interrupt flag rises only together with a matching state change;
- each flag holds while its clear is low.

Only the bench scenarios can show the rest: the exact read values of each dword, that byte enables and offsets are ignored where R5 says, that a set outweighs a same-cycle clear, and that responses arrive in order when `rsp_ready` is irregular.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pstate_e;

  localparam logic [7:0] CAP_ID_PM  = 8'h01;
  localparam logic [7:0] CAP_NEXT   = 8'h00;
  localparam logic [2:0] PM_VERSION = 3'b010;

  // Capability word: version, then optional-state support bits.
  function automatic logic [15:0] pm_cap_word(input bit d1_ok, input bit d2_ok);
    logic [15:0] w;
    w        = '0;
    w[2:0]   = PM_VERSION;
    w[9]     = d1_ok;
    w[10]    = d2_ok;
    return w;
  endfunction

endpackage

// File: rtl/pmc_decode.sv
module pmc_decode #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PTR_OFS  = 'h34,
  parameter logic [ADDR_W-1:0] CAP_BASE = 'h40
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_ptr,
  output logic              sel_cap,
  output logic              sel_csr
);
  localparam logic [ADDR_W-1:0] CSR_OFS = CAP_BASE + ADDR_W'(4);

  logic [ADDR_W-3:0] dw_idx;
  logic              unused_lsb;

  assign dw_idx     = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  assign sel_ptr = (dw_idx == PTR_OFS[ADDR_W-1:2]);
  assign sel_cap = (dw_idx == CAP_BASE[ADDR_W-1:2]);
  assign sel_csr = (dw_idx == CSR_OFS[ADDR_W-1:2]);
endmodule

// File: rtl/pmc_pstate.sv
module pmc_pstate
  import pmc_pkg::*;
#(
  parameter bit D1_SUP = 1'b1,
  parameter bit D2_SUP = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  pstate_e wr_target,
  output pstate_e cur,
  output logic    deeper_ev,
  output logic    wake_ev
);
  logic supported;

  always_comb begin
    unique case (wr_target)
      PS_D1:   supported = D1_SUP;
      PS_D2:   supported = D2_SUP;
      default: supported = 1'b1;
    endcase
    deeper_ev = wr_en && supported && (wr_target > cur);
    wake_ev   = wr_en && (wr_target == PS_D0) && (cur != PS_D0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cur <= PS_D0;
    else if (deeper_ev || wake_ev) cur <= wr_target;
  end
endmodule

// File: rtl/pmc_flag.sv
module pmc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PTR_OFS  = 'h34,
  parameter logic [ADDR_W-1:0] CAP_BASE = 'h40,
  parameter bit                D1_SUP   = 1'b1,
  parameter bit                D2_SUP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        pwr_state,
  output logic              pd_irq,
  input  logic              pd_clr,
  output logic              rs_irq,
  input  logic              rs_clr
);
  localparam logic [15:0] CAP_WORD = pm_cap_word(D1_SUP, D2_SUP);

  logic    sel_ptr, sel_cap, sel_csr;
  logic    accept, rd_acc, st_wr;
  logic    deeper_ev, wake_ev;
  pstate_e cur;
  logic [31:0] rd_word;
  logic    unused_wdata;

  assign unused_wdata = ^{req_wdata[31:2], req_be[3:1]};

  pmc_decode #(
    .ADDR_W  (ADDR_W),
    .PTR_OFS (PTR_OFS),
    .CAP_BASE(CAP_BASE)
  ) u_dec (
    .addr   (req_addr),
    .sel_ptr(sel_ptr),
    .sel_cap(sel_cap),
    .sel_csr(sel_csr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && !req_write;
  assign st_wr     = accept && req_write && sel_csr && req_be[0];

  pmc_pstate #(
    .D1_SUP(D1_SUP),
    .D2_SUP(D2_SUP)
  ) u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_wr),
    .wr_target(pstate_e'(req_wdata[1:0])),
    .cur      (cur),
    .deeper_ev(deeper_ev),
    .wake_ev  (wake_ev)
  );

  pmc_flag u_pd (.clk(clk), .rst_n(rst_n), .set(deeper_ev), .clr(pd_clr), .q(pd_irq));
  pmc_flag u_rs (.clk(clk), .rst_n(rst_n), .set(wake_ev),   .clr(rs_clr), .q(rs_irq));

  assign pwr_state = cur;

  always_comb begin
    rd_word = '0;
    if (sel_ptr)      rd_word = {{(32-ADDR_W){1'b0}}, CAP_BASE};
    else if (sel_cap) rd_word = {CAP_WORD, CAP_NEXT, CAP_ID_PM};
    else if (sel_csr) rd_word = {30'd0, cur};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [1:0]  pwr_state,
  input logic        pd_irq,
  input logic        pd_clr,
  input logic        rs_irq,
  input logic        rs_clr
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (pwr_state == 2'd0 && !pd_irq && !rs_irq && !rsp_valid));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_read_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_no_shallow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != $past(pwr_state) && pwr_state != 2'd0) |-> (pwr_state > $past(pwr_state)));

  p_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready && req_write) |-> $stable(pwr_state));

  p_pd_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_irq) |-> (pwr_state > $past(pwr_state)));

  p_rs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs_irq) |-> (pwr_state == 2'd0 && $past(pwr_state) != 2'd0));

  p_pd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_irq && !pd_clr) |=> pd_irq);

  p_rs_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_irq && !rs_clr) |=> rs_irq);
endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (.*);

// File: tb/tb_pmc_ctrl.sv
module tb_pmc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_ready = 1'b1;
  logic        pd_clr = 1'b0, rs_clr = 1'b0;
  logic        req_ready, rsp_valid, pd_irq, rs_irq;
  logic [31:0] rsp_rdata;
  logic [1:0]  pwr_state;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] exp_q[$];
  logic [1:0]  m_state = 2'd0;

  always #10 clk = ~clk;  // 50 MHz

  pmc_ctrl dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_ready <= (cyc % 3 != 1);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a response is taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected response", rsp_rdata, 32'hx);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R2/R3/R4/R9 read data", rsp_rdata, e);
      end
    end
  end

  task automatic send(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic pc);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be; pd_clr = pc;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0; pd_clr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e);
    exp_q.push_back(e);
    send(1'b0, a, 32'h0, 4'h0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be, input logic pc);
    send(1'b1, a, d, be, pc);
  endtask

  task automatic clear_both();
    @(negedge clk); pd_clr = 1'b1; rs_clr = 1'b1;
    @(negedge clk); pd_clr = 1'b0; rs_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pwr_state == 2'd0, "R1 state", {30'd0, pwr_state}, 0);
    chk(!pd_irq && !rs_irq, "R1 flags", {30'd0, pd_irq, rs_irq}, 0);
    chk(!rsp_valid && req_ready, "R1 channel", {30'd0, rsp_valid, req_ready}, 1);
    rst_n = 1'b1;

    rd(8'h34, 32'h0000_0040);              // R2
    rd(8'h40, 32'h0602_0001);              // R3
    rd(8'h42, 32'h0602_0001);              // R4 low bits ignored
    rd(8'h44, 32'h0);                      // R4 D0
    rd(8'h00, 32'h0);                      // R4 unmapped
    rd(8'h48, 32'h0);                      // R4 unmapped

    wr(8'h44, 32'h2, 4'h1, 1'b0);          // D0 -> D2
    chk(pwr_state == 2'd2, "R5 state to D2", {30'd0, pwr_state}, 2);
    chk(pd_irq && !rs_irq, "R7 pd on deeper", {30'd0, pd_irq, rs_irq}, 2);
    rd(8'h44, 32'h2);
    repeat (5) @(negedge clk);
    chk(pd_irq, "R8 pd sticky", {31'd0, pd_irq}, 1);
    clear_both();
    chk(!pd_irq, "R8 pd cleared", {31'd0, pd_irq}, 0);

    wr(8'h44, 32'h1, 4'h1, 1'b0);          // shallower non-D0: ignored
    chk(pwr_state == 2'd2, "R6 shallow ignored", {30'd0, pwr_state}, 2);
    chk(!pd_irq && !rs_irq, "R6 no flag", {30'd0, pd_irq, rs_irq}, 0);

    wr(8'h44, 32'h3, 4'hE, 1'b0);          // byte 0 disabled
    chk(pwr_state == 2'd2, "R5 be0 clear ignored", {30'd0, pwr_state}, 2);
    wr(8'h40, 32'h3, 4'hF, 1'b0);          // wrong offset
    chk(pwr_state == 2'd2, "R5 other offset ignored", {30'd0, pwr_state}, 2);
    chk(!pd_irq, "R5 no flag", {31'd0, pd_irq}, 0);

    wr(8'h44, 32'h3, 4'h1, 1'b1);          // D2 -> D3 with clear held
    chk(pwr_state == 2'd3, "R6 to D3", {30'd0, pwr_state}, 3);
    chk(pd_irq, "R8 set beats clear", {31'd0, pd_irq}, 1);

    wr(8'h44, 32'hFFFF_FFFC, 4'hF, 1'b0);  // back to D0
    chk(pwr_state == 2'd0, "R6 to D0", {30'd0, pwr_state}, 0);
    chk(rs_irq && pd_irq, "R7 rs on restore", {30'd0, pd_irq, rs_irq}, 3);
    rd(8'h44, 32'h0);                      // R4 ones written elsewhere read 0

    clear_both();
    wr(8'h44, 32'h0, 4'h1, 1'b0);          // same state
    chk(!pd_irq && !rs_irq, "R7 same state no flag", {30'd0, pd_irq, rs_irq}, 0);

    wr(8'h44, 32'h1, 4'h1, 1'b0);
    chk(pwr_state == 2'd1 && pd_irq, "R7 D1 deeper", {29'd0, pd_irq, pwr_state}, 5);
    wr(8'h44, 32'h2, 4'h1, 1'b0);
    chk(pwr_state == 2'd2, "R6 D1 to D2", {30'd0, pwr_state}, 2);

    for (int i = 0; i < 6; i++) begin     // R9 burst under back-pressure
      if (i % 2 == 0) rd(8'h44, 32'h2);
      else            rd(8'h40, 32'h0602_0001);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!rsp_valid, "R9 no extra response", {31'd0, rsp_valid}, 0);
    finish_run();
  end
endmodule